// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery

This block recovers a bit clock from a demodulated serial stream sampled once per clock cycle, where the clock runs at a fixed multiple of the bit rate (29 samples per bit by default). Each raw sample passes through a majority-vote filter. Transitions of the filtered stream are then compared against a free-running phase counter. The counter is pulled toward each transition, and the filtered level is captured at mid-bit. A one-cycle `dataValid` strobe presents each retimed bit, ready to be pushed into a receive FIFO.

Two correction gains are available. The fast gain removes half of the measured phase error at every transition, so it settles quickly. The slow gain moves the phase by a single tick per transition, which resists noise but tolerates less timing drift. The mode input selects fast, slow, or automatic tracking. In automatic tracking the fast gain is used until lock is found, the slow gain while lock holds, and the fast gain again once lock is lost. A lock flag reports whether recent transitions have been landing close to the expected bit boundary.

Top module: `bitClockRecovery`

## Requirements
- R1: While `rstN` is low, `dataValid`, `dataOut` and `locked` are 0, and the phase counter restarts at tick 0.
- R2: The filtered level is 1 when at least 3 of the last 5 raw samples are 1. Any isolated run of one or two samples against a steady level never reaches `dataOut`.
- R3: The phase counter counts ticks 0 to 28 and then wraps. With no filtered transition, `dataValid` pulses exactly once every 29 cycles.
- R4: `dataValid` is high for the single cycle that follows a cycle in which the phase counter is at tick 14. In that cycle `dataOut` carries the filtered level that was present at tick 14.
- R5: Fast gain: a filtered transition seen at tick p has phase error e, where e = p for p <= 14 and e = p - 29 otherwise. The next tick is (p + 1 - trunc(e/2)) mod 29, with the division truncating toward zero.
- R6: Slow gain: a filtered transition moves the next tick to (p + 1 - sign(e)) mod 29.
- R7: `locked` rises after 8 consecutive transitions whose error magnitude is at most 2.
- R8: `locked` falls after 4 consecutive transitions whose error magnitude exceeds 6. A transition with error magnitude from 3 to 6 breaks both streaks.
- R9: `modeSel` encoding: 0 selects the fast gain, 1 the slow gain, 2 and 3 automatic. `trackFast` shows the gain in use: in automatic mode it is 1 while unlocked and 0 while locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one raw sample per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| rawIn | input | 1 | Demodulated raw data sample |
| modeSel | input | 2 | Tracking gain select (0 fast, 1 slow, 2/3 automatic) |
| dataOut | output | 1 | Retimed data bit |
| dataValid | output | 1 | One-cycle strobe marking a new retimed bit |
| locked | output | 1 | Phase lock indication |
| trackFast | output | 1 | 1 when the fast gain is in use |

## Verification
A raw sample driven before edge n enters the filter window at edge n. It affects the filtered level from then on, and it can change the phase counter at edge n+1. A retimed bit appears on `dataValid` and `dataOut` one edge after the counter sits at tick 14. `locked` changes at the same edge that applies the correction for the qualifying transition, and `trackFast` follows `locked` and `modeSel` without delay. The bench runs a behavioural model that steps on each rising edge under these same latencies. It compares every output at the following falling edge, so each result is checked in exactly the cycle it becomes due.

// File: rtl/crPkg.sv
package crPkg;

  typedef enum logic [1:0] {
    MODE_FAST     = 2'd0,
    MODE_SLOW     = 2'd1,
    MODE_AUTO     = 2'd2,
    MODE_AUTO_ALT = 2'd3
  } trackMode_e;

  // Width of the error magnitude handed from datapath to control.
  localparam int ERR_W = 8;

  // Datapath to control: a transition was seen and how far it was off.
  typedef struct packed {
    logic             edgeSeen;
    logic [ERR_W-1:0] errMag;
  } edgeInfo_t;

  // Control to datapath: which loop gain applies this cycle.
  typedef struct packed {
    logic useFast;
  } ctrlStrobe_t;

endpackage

// File: rtl/crDatapath.sv
module crDatapath
  import crPkg::*;
#(
  parameter int OSR      = 29,
  parameter int VOTE_LEN = 5,
  parameter int VOTE_MIN = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawIn,
  input  ctrlStrobe_t ctrl,
  output edgeInfo_t   edgeInfo,
  output logic        dataOut,
  output logic        dataValid
);

  localparam int PHW = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [VOTE_LEN-1:0] hist;
  logic                filt;
  logic                filtPrev;
  logic                edgeDet;
  logic [PHW-1:0]      ph;
  logic [PHW-1:0]      phNext;
  int                  errS;
  int                  corr;
  int                  tmp;
  int                  mag;

  // Input history: the filter variant depends on the window length.
  generate
    if (VOTE_LEN > 1) begin : gWindow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else       hist <= {hist[VOTE_LEN-2:0], rawIn};
      end
    end else begin : gBypass
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hist <= '0;
        else       hist <= rawIn;
      end
    end
  endgenerate

  always_comb begin
    filt    = ($countones(hist) >= VOTE_MIN);
    edgeDet = filt ^ filtPrev;
  end

  // Phase error and next phase.
  always_comb begin
    if (int'(ph) <= MID) errS = int'(ph);
    else                 errS = int'(ph) - OSR;
    if (ctrl.useFast)    corr = errS / 2;
    else if (errS > 0)   corr = 1;
    else if (errS < 0)   corr = -1;
    else                 corr = 0;
    tmp = int'(ph) + 1;
    if (edgeDet) tmp = tmp - corr;
    if (tmp >= OSR)  tmp = tmp - OSR;
    else if (tmp < 0) tmp = tmp + OSR;
    phNext = PHW'(tmp);
    mag    = (errS < 0) ? -errS : errS;
  end

  always_comb begin
    edgeInfo.edgeSeen = edgeDet;
    edgeInfo.errMag   = ERR_W'(mag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtPrev  <= 1'b0;
      ph        <= '0;
      dataValid <= 1'b0;
      dataOut   <= 1'b0;
    end else begin
      filtPrev  <= filt;
      ph        <= phNext;
      dataValid <= (ph == PHW'(MID));
      if (ph == PHW'(MID)) dataOut <= filt;
    end
  end

  // Assertions

  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    ph < PHW'(OSR))
    else $error("phase counter out of range");

  p_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeDet && ph != PHW'(OSR - 1)) |=> (ph == $past(ph) + 1'b1))
    else $error("phase did not advance");

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeDet && ph == PHW'(OSR - 1)) |=> (ph == '0))
    else $error("phase did not wrap");

  p_valid_mid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PHW'(MID)) |=> (dataValid && dataOut == $past(filt)))
    else $error("mid-bit capture missing");

  p_valid_only_mid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ph != PHW'(MID)) |=> !dataValid)
    else $error("strobe away from mid-bit");

  p_fast_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && ctrl.useFast && ph == PHW'(MID)) |=> (ph == PHW'(MID + 1 - MID / 2)))
    else $error("fast correction wrong");

  p_slow_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (edgeDet && !ctrl.useFast && ph != '0 && ph <= PHW'(MID)) |=> (ph == $past(ph)))
    else $error("slow correction wrong");

endmodule

// File: rtl/crControl.sv
module crControl
  import crPkg::*;
#(
  parameter int GOOD_TOL = 2,
  parameter int BAD_TOL  = 6,
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  edgeInfo_t   edgeInfo,
  output ctrlStrobe_t ctrl,
  output logic        locked
);

  localparam int GCW = $clog2(GOOD_RUN + 1);
  localparam int BCW = $clog2(BAD_RUN + 1);

  trackMode_e     mode;
  logic           isGood;
  logic           isBad;
  logic [GCW-1:0] goodCnt;
  logic [BCW-1:0] badCnt;

  always_comb begin
    mode   = trackMode_e'(modeSel);
    isGood = edgeInfo.edgeSeen && (edgeInfo.errMag <= ERR_W'(GOOD_TOL));
    isBad  = edgeInfo.edgeSeen && (edgeInfo.errMag >  ERR_W'(BAD_TOL));
    case (mode)
      MODE_FAST: ctrl.useFast = 1'b1;
      MODE_SLOW: ctrl.useFast = 1'b0;
      default:   ctrl.useFast = !locked;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
      badCnt  <= '0;
      locked  <= 1'b0;
    end else if (edgeInfo.edgeSeen) begin
      if (isGood) begin
        badCnt <= '0;
        if (goodCnt != GCW'(GOOD_RUN)) goodCnt <= goodCnt + 1'b1;
        if (goodCnt >= GCW'(GOOD_RUN - 1)) locked <= 1'b1;
      end else if (isBad) begin
        goodCnt <= '0;
        if (badCnt != BCW'(BAD_RUN)) badCnt <= badCnt + 1'b1;
        if (badCnt >= BCW'(BAD_RUN - 1)) locked <= 1'b0;
      end else begin
        goodCnt <= '0;
        badCnt  <= '0;
      end
    end
  end

  // Assertions

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(isGood))
    else $error("lock set without a close transition");

  p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(isBad))
    else $error("lock cleared without a far transition");

endmodule

// File: rtl/bitClockRecovery.sv
module bitClockRecovery
  import crPkg::*;
#(
  parameter int OSR      = 29,
  parameter int VOTE_LEN = 5,
  parameter int VOTE_MIN = 3,
  parameter int GOOD_TOL = 2,
  parameter int BAD_TOL  = 6,
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic [1:0] modeSel,
  output logic       dataOut,
  output logic       dataValid,
  output logic       locked,
  output logic       trackFast
);

  ctrlStrobe_t ctrl;
  edgeInfo_t   edgeInfo;

  crDatapath #(
    .OSR      (OSR),
    .VOTE_LEN (VOTE_LEN),
    .VOTE_MIN (VOTE_MIN)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .ctrl      (ctrl),
    .edgeInfo  (edgeInfo),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

  crControl #(
    .GOOD_TOL (GOOD_TOL),
    .BAD_TOL  (BAD_TOL),
    .GOOD_RUN (GOOD_RUN),
    .BAD_RUN  (BAD_RUN)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .edgeInfo (edgeInfo),
    .ctrl     (ctrl),
    .locked   (locked)
  );

  assign trackFast = ctrl.useFast;

endmodule

// File: tb/tb_bitClockRecovery.sv
`timescale 1ns/1ps
module tb_bitClockRecovery;

  localparam int OSR = 29;
  localparam int MID = 14;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rawIn;
  logic [1:0] modeSel;
  logic       dataOut, dataValid, locked, trackFast;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmpOn  = 0;
  bit lvl    = 0;
  bit [31:0] lfsr = 32'hACE1_1234;
  int validCnt = 0;
  int validOne = 0;

  // Behavioural reference state
  bit mRaw[$];
  int mPh = 0;
  bit mPrev = 0, mLocked = 0, mValid = 0, mData = 0;
  int mGood = 0, mBad = 0;

  bitClockRecovery dut (
    .clk(clk), .rstN(rstN), .rawIn(rawIn), .modeSel(modeSel),
    .dataOut(dataOut), .dataValid(dataValid), .locked(locked), .trackFast(trackFast)
  );

  always #2 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkInt(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, stepped on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRaw = {};
      repeat (5) mRaw.push_back(1'b0);
      mPh = 0; mPrev = 0; mLocked = 0; mValid = 0; mData = 0;
      mGood = 0; mBad = 0;
      cmpOn = 1;
    end else begin
      int ones, err, c, nxt, magE;
      bit f, fastNow;
      ones = 0;
      foreach (mRaw[i]) ones += mRaw[i];
      f = (ones >= 3);
      mValid = (mPh == MID);
      if (mValid) mData = f;
      nxt = mPh + 1;
      if (f != mPrev) begin
        err  = (mPh <= MID) ? mPh : mPh - OSR;
        magE = (err < 0) ? -err : err;
        fastNow = (modeSel == 2'd0) || (modeSel[1] && !mLocked);
        if (fastNow) c = err / 2;
        else c = (err > 0) ? 1 : ((err < 0) ? -1 : 0);
        nxt = mPh + 1 - c;
        if (magE <= 2) begin
          mBad = 0; mGood++;
          if (mGood >= 8) mLocked = 1;
        end else if (magE > 6) begin
          mGood = 0; mBad++;
          if (mBad >= 4) mLocked = 0;
        end else begin
          mGood = 0; mBad = 0;
        end
      end
      mPh = ((nxt % OSR) + OSR) % OSR;
      mPrev = f;
      mRaw.push_back(rawIn);
      void'(mRaw.pop_front());
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      bit expFast;
      string gtag;
      gtag = (modeSel == 2'd0) ? "R5 strobe" : (modeSel == 2'd1) ? "R6 strobe" : "R9 strobe";
      expFast = (modeSel == 2'd0) || (modeSel[1] && !mLocked);
      check(dataValid, mValid, gtag);
      if (mValid) check(dataOut, mData, "R4 data");
      check(locked, mLocked, mLocked ? "R7 lock" : "R8 lock");
      check(trackFast, expFast, "R9 gain");
      if (dataValid) begin
        validCnt++;
        if (dataOut) validOne++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic stepLfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic hold(input int n);
    for (int k = 0; k < n; k++) begin
      rawIn = lvl;
      @(posedge clk); #1;
    end
  endtask

  task automatic sendBits(input int n, input int period, input bit randData, input bit noisy);
    for (int i = 0; i < n; i++) begin
      stepLfsr();
      if (randData) lvl = lfsr[5];
      else          lvl = ~lvl;
      for (int k = 0; k < period; k++) begin
        rawIn = lvl ^ (noisy && k == period / 2 && lfsr[3]);
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    rstN = 1'b0; rawIn = 1'b0; modeSel = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    check(dataValid, 1'b0, "R1 valid in reset");
    check(dataOut,   1'b0, "R1 data in reset");
    check(locked,    1'b0, "R1 lock in reset");
    check(trackFast, 1'b1, "R9 fast mode gain");
    modeSel = 2'd1; #0.5;
    check(trackFast, 1'b0, "R9 slow mode gain");
    modeSel = 2'd2; #0.5;
    check(trackFast, 1'b1, "R9 auto unlocked gain");
    @(posedge clk); #1;
    rstN = 1'b1; modeSel = 2'd0;

    // R2 and R3: short spikes on a steady low level, no transitions
    validCnt = 0; validOne = 0;
    for (int c = 0; c < 290; c++) begin
      rawIn = (c % 10 < 2);
      @(posedge clk); #1;
    end
    checkInt(validCnt, 10, "R3 strobes per 290 cycles");
    checkInt(validOne, 0,  "R2 spikes filtered");
    lvl = 0;

    // R5 and R7: fast acquisition
    modeSel = 2'd0;
    sendBits(60, OSR, 0, 0);
    @(negedge clk); check(locked, 1'b1, "R7 fast lock");
    @(posedge clk); #1;

    // R6 and R8: slow tracking, then a half-bit jump
    modeSel = 2'd1;
    sendBits(40, OSR, 0, 0);
    @(negedge clk); check(locked, 1'b1, "R7 slow hold");
    @(posedge clk); #1;
    hold(14);
    sendBits(8, OSR, 0, 0);
    @(negedge clk); check(locked, 1'b0, "R8 slow unlock");
    @(posedge clk); #1;

    // R9: automatic gain switching
    modeSel = 2'd2;
    sendBits(60, OSR, 0, 0);
    @(negedge clk);
    check(locked, 1'b1, "R7 auto lock");
    check(trackFast, 1'b0, "R9 auto slow when locked");
    @(posedge clk); #1;
    hold(14);
    sendBits(8, OSR, 0, 0);
    @(negedge clk);
    check(locked, 1'b0, "R8 auto unlock");
    check(trackFast, 1'b1, "R9 auto back to fast");
    @(posedge clk); #1;

    // Drift, random data and single-sample noise in every mode
    modeSel = 2'd0; sendBits(150, 28, 1, 1);
    modeSel = 2'd1; sendBits(150, 30, 1, 1);
    modeSel = 2'd3; sendBits(150, 31, 1, 1);
    modeSel = 2'd2; sendBits(100, 29, 1, 1);

    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule